// File: doc/BRIEF.md
# Power-Up and Fault Supervisor for an Off-Line PWM Controller

This block sequences the start of an off-line current-mode PWM controller and keeps it safe afterwards. It watches synchronous comparator flags for the supply, the line, the overload sense and an external protection pin, and it decides when the PWM may run. It also drives a soft-start reference code and the switch that charges the supply capacitor from the high-voltage line. Every time interval is counted in pulses of a tick input. The one exception is overvoltage qualification, which is counted in clock cycles.

The faults fall into two groups. A latched fault comes from a supply overvoltage or from the external protection pin, and it holds until the supply drops below its reset level. An auto-restart fault comes from an overload or a line undervoltage that lasts too long. It clears at the next undervoltage stop, and the controller then recharges the supply and soft-starts again. A line undervoltage cuts the run enable at once, even before its timer expires.

The soft-start code counts in units of one sixteenth of the full-scale reference. Code 8 is the starting level and code 16 marks the end of soft-start. Code 24 is the clamp, reached after 16 single-unit steps.

Top module: `pwr_fault_seq`

## Requirements
- R1: A pulse on vcc_start_i enables operation from the next clock edge, and a pulse on vcc_stop_i disables it. While operation is disabled, run_o is low. After reset, run_o is 0, startup_sw_o is 1, ss_code_o is 0 and both fault outputs are 0.
- R2: ss_code_o is 0 while operation is disabled. It loads 8 on the first clock edge after operation is enabled. It then rises by exactly 1 after every SS_STEP_TICKS tick pulses and saturates at 24.
- R3: Once ss_code_o has reached 16, startup_sw_o goes low after SW_DLY_TICKS further tick pulses. It returns to 1 on the clock edge where vcc_stop_i is high.
- R4: vcc_ovp_i held high for OVP_CYC consecutive clock cycles sets latch_flt_o. A shorter burst sets nothing, and any low cycle restarts the count.
- R5: latch_pin_i high for a single cycle sets latch_flt_o on the following clock edge.
- R6: latch_flt_o stays set through stop and start cycles and clears only on a cycle with vcc_rst_i high. While it is set, run_o is low.
- R7: The overload timer advances one step per tick only while osc_high_i and olp_sense_i are both high. A cycle with osc_high_i high and olp_sense_i low clears it. When the timer reaches FLT_TICKS, ar_flt_o is set and run_o goes low.
- R8: line_uv_i forces run_o low in the same cycle. If line_uv_i stays high for FLT_TICKS ticks, ar_flt_o is set and run_o stays low after line_uv_i clears.
- R9: ar_flt_o clears only on the clock edge where vcc_stop_i is high. If line_uv_i releases before its timer expires, run_o returns with no fault.
- R10: While osc_high_i is low, the overload timer neither advances nor clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| vcc_start_i | input | 1 | Supply has reached the start level |
| vcc_stop_i | input | 1 | Supply has fallen to the stop level |
| vcc_rst_i | input | 1 | Supply is below the latch-reset level |
| vcc_ovp_i | input | 1 | Supply overvoltage comparator |
| latch_pin_i | input | 1 | External protection pin above its trip level |
| line_uv_i | input | 1 | Line undervoltage comparator |
| olp_sense_i | input | 1 | Feedback offset below the overload level |
| osc_high_i | input | 1 | Oscillator clock-high phase |
| run_o | output | 1 | PWM run enable |
| startup_sw_o | output | 1 | Start-up charging switch closed |
| ss_code_o | output | SS_W | Soft-start reference code |
| latch_flt_o | output | 1 | Latched fault active |
| ar_flt_o | output | 1 | Auto-restart fault active |

## Verification
The assertions assume that vcc_start_i and vcc_stop_i are never high together, and that vcc_rst_i only rises while the supply is stopped. Physically, these flags come from ordered thresholds on a single voltage. The stimulus pulses each supply flag on its own, for one cycle, and raises vcc_rst_i only after a stop. Ticks arrive as single-cycle pulses every third cycle. Fault inputs are held across whole tick periods, so qualification windows both expire and break partway through.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  function automatic int unsigned cnt_w(int unsigned max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pfs_qual_timer.sv
module pfs_qual_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned CW = pfs_pkg::cnt_w(LIMIT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));

  // R7
  timer_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);
endmodule

// File: rtl/pfs_ss_ramp.sv
module pfs_ss_ramp #(
  parameter int unsigned SS_STEPS      = 16,
  parameter int unsigned SS_STEP_TICKS = 10,
  localparam int unsigned SS_W = pfs_pkg::cnt_w(SS_STEPS + SS_STEPS / 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  output logic [SS_W-1:0] code_o,
  output logic            done_o
);
  localparam int unsigned DW    = pfs_pkg::cnt_w(SS_STEP_TICKS);
  localparam int unsigned START = SS_STEPS / 2;
  localparam int unsigned MID   = SS_STEPS;
  localparam int unsigned CLAMP = SS_STEPS + SS_STEPS / 2;

  logic [SS_W-1:0] code_q;
  logic [DW-1:0]   div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      div_q  <= '0;
    end else if (!en_i) begin
      code_q <= '0;
      div_q  <= '0;
    end else if (code_q == '0) begin
      code_q <= SS_W'(START);
    end else if (tick_i) begin
      if (div_q == DW'(SS_STEP_TICKS - 1)) begin
        div_q <= '0;
        if (code_q != SS_W'(CLAMP)) code_q <= code_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign done_o = (code_q >= SS_W'(MID));

  // R2
  ss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && code_q != '0 |=> code_q == $past(code_q) || code_q == SS_W'($past(code_q) + 1'b1));
  // R2
  ss_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> code_q == '0);
endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq #(
  parameter int unsigned SS_STEPS      = 16,
  parameter int unsigned SS_STEP_TICKS = 10,
  parameter int unsigned SW_DLY_TICKS  = 40,
  parameter int unsigned FLT_TICKS     = 176,
  parameter int unsigned OVP_CYC       = 550,
  localparam int unsigned SS_W = pfs_pkg::cnt_w(SS_STEPS + SS_STEPS / 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            vcc_start_i,
  input  logic            vcc_stop_i,
  input  logic            vcc_rst_i,
  input  logic            vcc_ovp_i,
  input  logic            latch_pin_i,
  input  logic            line_uv_i,
  input  logic            olp_sense_i,
  input  logic            osc_high_i,
  output logic            run_o,
  output logic            startup_sw_o,
  output logic [SS_W-1:0] ss_code_o,
  output logic            latch_flt_o,
  output logic            ar_flt_o
);
  logic vcc_on_q, sw_off_q, latch_q, ar_q;
  logic ss_done, sw_done, ovp_done, olp_done, luv_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vcc_on_q <= 1'b0;
    else if (vcc_stop_i)  vcc_on_q <= 1'b0;
    else if (vcc_start_i) vcc_on_q <= 1'b1;
  end

  pfs_ss_ramp #(.SS_STEPS(SS_STEPS), .SS_STEP_TICKS(SS_STEP_TICKS)) ramp_i (
    .clk_i, .rst_ni, .en_i(vcc_on_q), .tick_i, .code_o(ss_code_o), .done_o(ss_done));

  pfs_qual_timer #(.LIMIT(SW_DLY_TICKS)) sw_tmr_i (
    .clk_i, .rst_ni, .clr_i(!vcc_on_q), .inc_i(tick_i && ss_done), .done_o(sw_done));

  pfs_qual_timer #(.LIMIT(OVP_CYC)) ovp_tmr_i (
    .clk_i, .rst_ni, .clr_i(!vcc_ovp_i), .inc_i(vcc_ovp_i), .done_o(ovp_done));

  // overload sense only qualifies during the clock-high phase
  pfs_qual_timer #(.LIMIT(FLT_TICKS)) olp_tmr_i (
    .clk_i, .rst_ni,
    .clr_i(!vcc_on_q || (osc_high_i && !olp_sense_i)),
    .inc_i(tick_i && osc_high_i && olp_sense_i),
    .done_o(olp_done));

  pfs_qual_timer #(.LIMIT(FLT_TICKS)) luv_tmr_i (
    .clk_i, .rst_ni, .clr_i(!vcc_on_q || !line_uv_i), .inc_i(tick_i && line_uv_i),
    .done_o(luv_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_off_q <= 1'b0;
      latch_q  <= 1'b0;
      ar_q     <= 1'b0;
    end else begin
      if (vcc_stop_i)                sw_off_q <= 1'b0;
      else if (sw_done && vcc_on_q)  sw_off_q <= 1'b1;

      if (vcc_rst_i)                     latch_q <= 1'b0;
      else if (ovp_done || latch_pin_i)  latch_q <= 1'b1;

      if (vcc_stop_i)                                ar_q <= 1'b0;
      else if (vcc_on_q && (olp_done || luv_done))   ar_q <= 1'b1;
    end
  end

  assign run_o        = vcc_on_q && !latch_q && !ar_q && !line_uv_i;
  assign startup_sw_o = !sw_off_q;
  assign latch_flt_o  = latch_q;
  assign ar_flt_o     = ar_q;

  // R4
  latch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(latch_pin_i) || $past(ovp_done));
  // R6
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_q && !vcc_rst_i |=> latch_q);
  // R9
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_q && !vcc_stop_i |=> ar_q);
  // R3
  sw_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(startup_sw_o) |-> ss_done);
endmodule

// File: tb/pwr_fault_seq_tb_top.sv
module pwr_fault_seq_tb_top;
  localparam int STEP = 2, SWD = 4, FLT = 6, OVP = 5;
  localparam int START = 8, MID = 16, CLAMP = 24;

  logic clk = 0, rst_ni = 0;
  logic tick_i = 0, vcc_start_i = 0, vcc_stop_i = 0, vcc_rst_i = 0, vcc_ovp_i = 0;
  logic latch_pin_i = 0, line_uv_i = 0, olp_sense_i = 0, osc_high_i = 0;
  logic run_o, startup_sw_o, latch_flt_o, ar_flt_o;
  logic [4:0] ss_code_o;

  int n_chk = 0, n_fail = 0, tick_cnt = 0;
  bit finished = 0;

  // reference state
  int m_on = 0, m_code = 0, m_div = 0, m_swoff = 0, m_swc = 0, m_latch = 0;
  int m_ovpc = 0, m_olpc = 0, m_luvc = 0, m_ar = 0;

  always #2 clk = ~clk;

  pwr_fault_seq #(.SS_STEPS(16), .SS_STEP_TICKS(STEP), .SW_DLY_TICKS(SWD),
                  .FLT_TICKS(FLT), .OVP_CYC(OVP)) dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .vcc_start_i, .vcc_stop_i, .vcc_rst_i, .vcc_ovp_i,
    .latch_pin_i, .line_uv_i, .olp_sense_i, .osc_high_i, .run_o, .startup_sw_o,
    .ss_code_o, .latch_flt_o, .ar_flt_o);

  always @(negedge clk) begin
    tick_i   <= (tick_cnt == 0);
    tick_cnt <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
  end

  always @(posedge clk) begin
    int o_on, o_code, o_swc, o_ovpc, o_olpc, o_luvc;
    o_on = m_on; o_code = m_code; o_swc = m_swc;
    o_ovpc = m_ovpc; o_olpc = m_olpc; o_luvc = m_luvc;
    if (!rst_ni) begin
      m_on = 0; m_code = 0; m_div = 0; m_swoff = 0; m_swc = 0; m_latch = 0;
      m_ovpc = 0; m_olpc = 0; m_luvc = 0; m_ar = 0;
    end else begin
      if (vcc_stop_i) m_on = 0; else if (vcc_start_i) m_on = 1;
      if (!o_on) begin m_code = 0; m_div = 0; end
      else if (o_code == 0) m_code = START;
      else if (tick_i) begin
        if (m_div == STEP - 1) begin m_div = 0; if (m_code < CLAMP) m_code++; end
        else m_div++;
      end
      if (!o_on) m_swc = 0; else if (tick_i && o_code >= MID && m_swc < SWD) m_swc++;
      if (vcc_stop_i) m_swoff = 0; else if (o_swc == SWD && o_on) m_swoff = 1;
      if (!vcc_ovp_i) m_ovpc = 0; else if (m_ovpc < OVP) m_ovpc++;
      if (vcc_rst_i) m_latch = 0; else if (o_ovpc == OVP || latch_pin_i) m_latch = 1;
      if (!o_on || (osc_high_i && !olp_sense_i)) m_olpc = 0;
      else if (tick_i && osc_high_i && olp_sense_i && m_olpc < FLT) m_olpc++;
      if (!o_on || !line_uv_i) m_luvc = 0;
      else if (tick_i && m_luvc < FLT) m_luvc++;
      if (vcc_stop_i) m_ar = 0; else if (o_on && (o_olpc == FLT || o_luvc == FLT)) m_ar = 1;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_ni && !finished) begin
      chk("R1 R6 R8 run_o", run_o, (m_on && !m_latch && !m_ar && !line_uv_i) ? 1 : 0);
      chk("R2 ss_code_o", ss_code_o, m_code);
      chk("R3 startup_sw_o", startup_sw_o, m_swoff ? 0 : 1);
      chk("R4 R5 latch_flt_o", latch_flt_o, m_latch);
      chk("R7 R9 ar_flt_o", ar_flt_o, m_ar);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    cyc(3); rst_ni = 1;
    settle();
    chk("R1 reset run", run_o, 0); chk("R1 reset sw", startup_sw_o, 1);
    chk("R1 reset code", ss_code_o, 0);
    chk("R1 reset flt", {30'd0, latch_flt_o, ar_flt_o}, 0);

    pulse(vcc_start_i); settle();
    chk("R2 first code", ss_code_o, START);
    chk("R3 sw closed during ramp", startup_sw_o, 1);
    cyc(150); settle();
    chk("R2 clamp", ss_code_o, CLAMP); chk("R3 sw open", startup_sw_o, 0);
    chk("R1 running", run_o, 1);

    // R8 short line dip, R9 recovery
    @(negedge clk); line_uv_i = 1; #1;
    chk("R8 immediate off", run_o, 0);
    cyc(9); line_uv_i = 0; cyc(2); settle();
    chk("R9 resume", run_o, 1); chk("R9 no fault", ar_flt_o, 0);

    // R7 overload, R10 hold during osc low
    @(negedge clk); osc_high_i = 1; olp_sense_i = 1;
    cyc(12); osc_high_i = 0; olp_sense_i = 0;
    cyc(9); settle();
    chk("R10 held", ar_flt_o, 0);
    osc_high_i = 1; olp_sense_i = 1; cyc(9); settle();
    chk("R10 resumed count", ar_flt_o, 1);
    chk("R7 run off", run_o, 0);
    osc_high_i = 0; olp_sense_i = 0;

    pulse(vcc_stop_i); settle();
    chk("R9 cleared", ar_flt_o, 0); chk("R3 sw reclosed", startup_sw_o, 1);
    chk("R2 code idle", ss_code_o, 0);

    // R4 overvoltage
    pulse(vcc_start_i); cyc(30);
    @(negedge clk); vcc_ovp_i = 1; cyc(3); vcc_ovp_i = 0; cyc(3); settle();
    chk("R4 short burst", latch_flt_o, 0);
    vcc_ovp_i = 1; cyc(8); vcc_ovp_i = 0; settle();
    chk("R4 latched", latch_flt_o, 1); chk("R6 run off", run_o, 0);

    // R6 hold through restart
    pulse(vcc_stop_i); pulse(vcc_start_i); cyc(10); settle();
    chk("R6 kept", latch_flt_o, 1); chk("R6 run still off", run_o, 0);
    pulse(vcc_stop_i); pulse(vcc_rst_i); settle();
    chk("R6 cleared", latch_flt_o, 0);

    // R5 latch pin
    pulse(vcc_start_i); cyc(20);
    pulse(latch_pin_i); #1;
    chk("R5 pin latched", latch_flt_o, 1);
    pulse(vcc_stop_i); pulse(vcc_rst_i); pulse(vcc_start_i); cyc(20);

    // R8 long line undervoltage
    @(negedge clk); line_uv_i = 1; cyc(30); line_uv_i = 0; cyc(2); settle();
    chk("R8 fault set", ar_flt_o, 1); chk("R8 stays off", run_o, 0);
    pulse(vcc_stop_i); settle();
    chk("R9 cleared by stop", ar_flt_o, 0);
    cyc(5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule